// File: doc/BRIEF.md
# Paired-Ring Memory Copy Engine

The engine moves blocks of 32-bit words from one memory region to another under the control of two descriptor rings in shared memory. The source ring names where data comes from and how many bytes to move. The destination ring, at the same slot, names where the data goes. Software fills source and destination slots, then advances the source ring's host index. The engine works through the slots from its own index up to that host index. For each slot it fetches the descriptors, copies the words, and writes a completion flag back into the destination slot. It then moves its index on by one.

Configuration and status live in a small 32-bit register space. Each ring has a base address, an entry count (a power of two), a host index and an engine index. There is also a global control word with per-side enable and busy bits, and a per-side ring-reset word. Memory is reached through a single word-wide request/acknowledge master. A one-cycle completion event per finished slot feeds a downstream interrupt coalescer.

Top module: `ringcpy_engine`

## Requirements
- R1: After reset every register reads zero, `mem_req` is low and `done_evt` is low.
- R2: A new slot is started only when both side enables (control bits 0 and 2) are set, neither ring-reset bit is set, and the source engine index differs from the source host index; otherwise no memory request is made.
- R3: Ring slots are 16 bytes apart, so slot i sits at base + 16*i. For each slot the engine reads, in this order, source word 0 (source address, offset +0), source word 1 (offset +4) and destination word 0 (destination address, offset +0).
- R4: The byte length is bits 29:16 of source word 1. The engine moves length/4 words, each as a read at the source address followed by a write of the same data at the destination address, both ascending by 4. A zero length moves no data.
- R5: After the last data word, the engine writes destination word 1 (offset +4) with bit 31 set as the done flag, bits 29:16 holding the length, and all other bits zero.
- R6: Once the write-back is acknowledged, the engine indices of both rings become (i+1) masked by (count-1). With a count of 8 this wraps from 7 to 0.
- R7: `done_evt` is high for exactly one cycle, the cycle after the write-back is acknowledged, once per slot.
- R8: Control bits 1 (source busy) and 3 (destination busy) read 1 while a slot is in progress. Clearing the enables lets the current slot complete, and then no further slot is started.
- R9: While reset bit 0 (source) or bit 16 (destination) of the word at 0x208 is set, that ring's engine index reads zero.
- R10: Register map: source ring at 0x000/0x004/0x008/0x00C (base, count, host index, engine index), destination ring at 0x100 to 0x10C in the same layout, control at 0x204, ring reset at 0x208. Written values read back.
- R11: A memory request keeps its address, direction and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| done_evt | output | 1 | One-cycle pulse per completed slot |

## Verification
The bench builds the engine with IDX_W = 3 and programs a ring count of 8. At that size a run of a few slots crosses the 7-to-0 index wrap, and the one-unused-slot limit is reached with short data blocks. ADDR_W stays at 32, and all rings and buffers are placed inside a 4 KB bench memory. The memory acknowledges at random, which stretches each phase of the slot sequence by varying amounts. This lets the busy and drain behaviour be observed while a long copy is still running.

// File: rtl/rce_pkg.sv
package rce_pkg;
  localparam int DATA_W   = 32;
  localparam int LEN_LSB  = 16;
  localparam int LEN_W    = 14;
  localparam int WORDS_W  = LEN_W - 2;
  localparam int DONE_BIT = 31;
  localparam int SLOT_SH  = 4;

  localparam logic [1:0] FLD_BASE = 2'd0;
  localparam logic [1:0] FLD_CNT  = 2'd1;
  localparam logic [1:0] FLD_CPU  = 2'd2;
  localparam logic [1:0] FLD_ENG  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SADDR, ST_LEN, ST_DADDR, ST_RDATA, ST_WDATA, ST_WBACK
  } eng_state_e;
endpackage

// File: rtl/rce_ring_ctx.sv
module rce_ring_ctx
  import rce_pkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_field,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hold_zero,
  input  logic              adv,
  output logic [ADDR_W-1:0] base,
  output logic [IDX_W:0]    cnt,
  output logic [IDX_W-1:0]  cpu,
  output logic [IDX_W-1:0]  eng
);
  logic [IDX_W-1:0] mask;
  logic             base_ce, cnt_ce, cpu_ce, eng_ce;
  logic [IDX_W-1:0] eng_n;

  assign mask    = cnt[IDX_W-1:0] - 1'b1;
  assign base_ce = wr_en && (wr_field == FLD_BASE);
  assign cnt_ce  = wr_en && (wr_field == FLD_CNT);
  assign cpu_ce  = wr_en && (wr_field == FLD_CPU);

  always_comb begin
    eng_ce = 1'b1;
    eng_n  = eng;
    if (hold_zero)                          eng_n = '0;
    else if (adv)                           eng_n = (eng + 1'b1) & mask;
    else if (wr_en && wr_field == FLD_ENG)  eng_n = wr_data[IDX_W-1:0];
    else                                    eng_ce = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      cnt  <= '0;
      cpu  <= '0;
      eng  <= '0;
    end else begin
      if (base_ce) base <= wr_data[ADDR_W-1:0];
      if (cnt_ce)  cnt  <= wr_data[IDX_W:0];
      if (cpu_ce)  cpu  <= wr_data[IDX_W-1:0];
      if (eng_ce)  eng  <= eng_n;
    end
  end

  // R9: a held ring reset leaves the engine index at zero
  a_r9_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hold_zero |=> (eng == '0));

  // R6: an advanced index never leaves the ring
  a_r6_idx_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !hold_zero && !cnt_ce && cnt != '0) |=> ({1'b0, eng} < cnt));
endmodule

// File: rtl/rce_copy_fsm.sv
module rce_copy_fsm
  import rce_pkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_ok,
  input  logic [ADDR_W-1:0] s_base,
  input  logic [ADDR_W-1:0] d_base,
  input  logic [IDX_W-1:0]  s_eng,
  input  logic [IDX_W-1:0]  d_eng,
  input  logic [IDX_W-1:0]  s_cpu,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              adv,
  output logic              done_evt,
  output logic              active
);
  eng_state_e        state, state_n;
  logic [ADDR_W-1:0] src_ptr, src_ptr_n, dst_ptr, dst_ptr_n;
  logic [WORDS_W-1:0] left, left_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic [DATA_W-1:0] hold, hold_n;
  logic [ADDR_W-1:0] s_slot, d_slot;
  logic [DATA_W-1:0] wb_word;

  assign s_slot = s_base + (ADDR_W'(s_eng) << SLOT_SH);
  assign d_slot = d_base + (ADDR_W'(d_eng) << SLOT_SH);
  assign active = (state != ST_IDLE);

  always_comb begin
    wb_word = '0;
    wb_word[DONE_BIT] = 1'b1;
    wb_word[LEN_LSB +: LEN_W] = len_q;
  end

  always_comb begin
    state_n   = state;
    src_ptr_n = src_ptr;
    dst_ptr_n = dst_ptr;
    left_n    = left;
    len_n     = len_q;
    hold_n    = hold;
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    adv       = 1'b0;
    case (state)
      ST_IDLE: begin
        mem_req = 1'b0;
        if (run_ok && (s_eng != s_cpu)) state_n = ST_SADDR;
      end
      ST_SADDR: begin
        mem_addr = s_slot;
        if (mem_ack) begin
          src_ptr_n = mem_rdata[ADDR_W-1:0];
          state_n   = ST_LEN;
        end
      end
      ST_LEN: begin
        mem_addr = s_slot + ADDR_W'(4);
        if (mem_ack) begin
          len_n   = mem_rdata[LEN_LSB +: LEN_W];
          left_n  = mem_rdata[LEN_LSB+2 +: WORDS_W];
          state_n = ST_DADDR;
        end
      end
      ST_DADDR: begin
        mem_addr = d_slot;
        if (mem_ack) begin
          dst_ptr_n = mem_rdata[ADDR_W-1:0];
          state_n   = (left == '0) ? ST_WBACK : ST_RDATA;
        end
      end
      ST_RDATA: begin
        mem_addr = src_ptr;
        if (mem_ack) begin
          hold_n    = mem_rdata;
          src_ptr_n = src_ptr + ADDR_W'(4);
          state_n   = ST_WDATA;
        end
      end
      ST_WDATA: begin
        mem_we    = 1'b1;
        mem_addr  = dst_ptr;
        mem_wdata = hold;
        if (mem_ack) begin
          dst_ptr_n = dst_ptr + ADDR_W'(4);
          left_n    = left - 1'b1;
          state_n   = (left == WORDS_W'(1)) ? ST_WBACK : ST_RDATA;
        end
      end
      ST_WBACK: begin
        mem_we    = 1'b1;
        mem_addr  = d_slot + ADDR_W'(4);
        mem_wdata = wb_word;
        if (mem_ack) begin
          adv     = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      src_ptr  <= '0;
      dst_ptr  <= '0;
      left     <= '0;
      len_q    <= '0;
      hold     <= '0;
      done_evt <= 1'b0;
    end else begin
      state    <= state_n;
      src_ptr  <= src_ptr_n;
      dst_ptr  <= dst_ptr_n;
      left     <= left_n;
      len_q    <= len_n;
      hold     <= hold_n;
      done_evt <= adv;
    end
  end

  // R11: an unaccepted request is held unchanged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  // R7: completion event lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !done_evt);

  // R3: a slot always opens with a read of the source slot's first word
  a_r3_first_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (mem_req && !mem_we && mem_addr == s_slot));

  // R2: work only starts with both sides enabled
  a_r2_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(run_ok));
endmodule

// File: rtl/ringcpy_engine.sv
module ringcpy_engine
  import rce_pkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              done_evt
);
  localparam int NRING = 2;

  logic [ADDR_W-1:0] r_base [NRING];
  logic [IDX_W:0]    r_cnt  [NRING];
  logic [IDX_W-1:0]  r_cpu  [NRING];
  logic [IDX_W-1:0]  r_eng  [NRING];
  logic [NRING-1:0]  ring_hit;
  logic [NRING-1:0]  en_q, en_n, rst_q, rst_n_v;
  logic              ctrl_hit, rrst_hit, run_ok, eng_adv, eng_active;

  assign ring_hit[0] = (reg_addr[11:4] == 8'h00);
  assign ring_hit[1] = (reg_addr[11:4] == 8'h10);
  assign ctrl_hit    = (reg_addr == 12'h204);
  assign rrst_hit    = (reg_addr == 12'h208);

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    rce_ring_ctx #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr && ring_hit[g]),
      .wr_field  (reg_addr[3:2]),
      .wr_data   (reg_wdata),
      .hold_zero (rst_q[g]),
      .adv       (eng_adv),
      .base      (r_base[g]),
      .cnt       (r_cnt[g]),
      .cpu       (r_cpu[g]),
      .eng       (r_eng[g])
    );
  end

  always_comb begin
    en_n    = en_q;
    rst_n_v = rst_q;
    if (reg_wr && ctrl_hit) en_n    = {reg_wdata[2], reg_wdata[0]};
    if (reg_wr && rrst_hit) rst_n_v = {reg_wdata[16], reg_wdata[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      rst_q <= '0;
    end else begin
      en_q  <= en_n;
      rst_q <= rst_n_v;
    end
  end

  assign run_ok = (&en_q) && !(|rst_q);

  rce_copy_fsm #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_ok    (run_ok),
    .s_base    (r_base[0]),
    .d_base    (r_base[1]),
    .s_eng     (r_eng[0]),
    .d_eng     (r_eng[1]),
    .s_cpu     (r_cpu[0]),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .adv       (eng_adv),
    .done_evt  (done_evt),
    .active    (eng_active)
  );

  always_comb begin
    reg_rdata = '0;
    if (ctrl_hit) begin
      reg_rdata[0] = en_q[0];
      reg_rdata[1] = eng_active;
      reg_rdata[2] = en_q[1];
      reg_rdata[3] = eng_active;
    end else if (rrst_hit) begin
      reg_rdata[0]  = rst_q[0];
      reg_rdata[16] = rst_q[1];
    end else begin
      for (int i = 0; i < NRING; i++) begin
        if (ring_hit[i]) begin
          case (reg_addr[3:2])
            FLD_BASE: reg_rdata = 32'(r_base[i]);
            FLD_CNT:  reg_rdata = 32'(r_cnt[i]);
            FLD_CPU:  reg_rdata = 32'(r_cpu[i]);
            default:  reg_rdata = 32'(r_eng[i]);
          endcase
        end
      end
    end
  end

  // R8: memory traffic only while a slot is in progress
  a_r8_req_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> eng_active);
endmodule

// File: tb/ringcpy_engine_tb.sv
module ringcpy_engine_tb;
  localparam int IDX_W = 3;
  localparam logic [31:0] SB = 32'h100, DB = 32'h200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 1'b0, done_evt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  int vectors = 0, miscompares = 0, cycles = 0;
  logic [31:0] mem [0:1023];
  logic        q_we[$];
  logic [31:0] q_addr[$], q_data[$];
  logic        q_last[$];
  logic        exp_done = 1'b0;

  always #2.5 clk = ~clk;

  ringcpy_engine #(.IDX_W(IDX_W), .ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done_evt(done_evt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Memory responder and per-cycle reference comparison
  always @(negedge clk) begin
    cycles++;
    if (rst_n) chk("R7 done_evt", {31'd0, done_evt}, {31'd0, exp_done});
    exp_done = 1'b0;
    mem_ack  = 1'b0;
    if (rst_n && mem_req && ($urandom % 4 != 0)) begin
      mem_ack = 1'b1;
      if (q_addr.size() == 0) begin
        chk("R2 unexpected request", mem_addr, 32'hFFFF_FFFF);
      end else begin
        chk("R3/R4 bus direction", {31'd0, mem_we}, {31'd0, q_we[0]});
        chk("R3/R4 bus address", mem_addr, q_addr[0]);
        if (q_we[0]) chk("R4/R5 write data", mem_wdata, q_data[0]);
        exp_done = q_last[0];
        void'(q_we.pop_front()); void'(q_addr.pop_front());
        void'(q_data.pop_front()); void'(q_last.pop_front());
      end
      if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
      else        mem_rdata = mem[mem_addr[11:2]];
    end
  end

  task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d, input logic last);
    q_we.push_back(we); q_addr.push_back(a); q_data.push_back(d); q_last.push_back(last);
  endtask

  task automatic set_slot(input int idx, input logic [31:0] s, input logic [31:0] d, input int len);
    mem[(SB + idx*16) >> 2]     = s;
    mem[(SB + idx*16 + 4) >> 2] = 32'(len) << 16;
    mem[(DB + idx*16) >> 2]     = d;
    mem[(DB + idx*16 + 4) >> 2] = '0;
    for (int k = 0; k < len/4; k++) begin
      mem[(s >> 2) + k] = $urandom;
      mem[(d >> 2) + k] = '0;
    end
  endtask

  // Reference: the bus sequence one slot must produce
  task automatic model_slot(input int idx);
    logic [31:0] s, d; int len;
    s   = mem[(SB + idx*16) >> 2];
    len = int'(mem[(SB + idx*16 + 4) >> 2][29:16]);
    d   = mem[(DB + idx*16) >> 2];
    push(1'b0, SB + idx*16, '0, 1'b0);
    push(1'b0, SB + idx*16 + 4, '0, 1'b0);
    push(1'b0, DB + idx*16, '0, 1'b0);
    for (int k = 0; k < len/4; k++) begin
      push(1'b0, s + 4*k, '0, 1'b0);
      push(1'b1, d + 4*k, mem[(s >> 2) + k], 1'b0);
    end
    push(1'b1, DB + idx*16 + 4, 32'h8000_0000 | (32'(len) << 16), 1'b1);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #0.5 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (q_addr.size() == 0 && !mem_req) break;
    end
    repeat (3) @(negedge clk);
    rd(12'h204, c);
    chk("R8 busy cleared when drained", c & 32'hA, 32'h0);
  endtask

  task automatic chk_copy(input int idx);
    logic [31:0] s, d; int len;
    s   = mem[(SB + idx*16) >> 2];
    len = int'(mem[(SB + idx*16 + 4) >> 2][29:16]);
    d   = mem[(DB + idx*16) >> 2];
    for (int k = 0; k < len/4; k++) chk("R4 copied word", mem[(d >> 2) + k], mem[(s >> 2) + k]);
    chk("R5 done write-back", mem[(DB + idx*16 + 4) >> 2], 32'h8000_0000 | (32'(len) << 16));
  endtask

  task automatic chk_idx(input string req, input logic [31:0] e);
    logic [31:0] v;
    rd(12'h00C, v); chk(req, v, e);
    rd(12'h10C, v); chk(req, v, e);
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rd(12'h000, v); chk("R1 reset src base", v, 0);
    rd(12'h204, v); chk("R1 reset ctrl", v, 0);
    chk("R1 reset mem_req", {31'd0, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done_evt low", {31'd0, done_evt}, 0);

    wr(12'h000, SB); wr(12'h004, 8); wr(12'h100, DB); wr(12'h104, 8); wr(12'h108, 7);
    rd(12'h000, v); chk("R10 src base readback", v, SB);
    rd(12'h108, v); chk("R10 dst host index readback", v, 7);
    wr(12'h204, 32'h5);
    rd(12'h204, v); chk("R10 ctrl readback", v, 32'h5);

    // three slots, including a zero-length one
    set_slot(0, 32'h400, 32'h800, 8);
    set_slot(1, 32'h440, 32'h840, 12);
    set_slot(2, 32'h480, 32'h880, 0);
    for (int i = 0; i < 3; i++) model_slot(i);
    wr(12'h008, 3);
    wait_idle();
    for (int i = 0; i < 3; i++) chk_copy(i);
    chk_idx("R6 index after three slots", 3);

    // disabled: posted work must not start
    wr(12'h204, 32'h0);
    set_slot(3, 32'h4C0, 32'h8C0, 4);
    wr(12'h008, 4);
    repeat (40) @(negedge clk);
    chk_idx("R2 no start while disabled", 3);
    model_slot(3);
    wr(12'h204, 32'h5);
    wait_idle();
    chk_copy(3);
    chk_idx("R2 start after enable", 4);

    // drain: long slot in flight when enables drop
    set_slot(4, 32'h500, 32'h900, 64);
    set_slot(5, 32'h5C0, 32'h9C0, 4);
    model_slot(4);
    wr(12'h008, 6);
    repeat (4) @(negedge clk);
    wr(12'h204, 32'h0);
    rd(12'h204, v); chk("R8 busy during drain", v, 32'hA);
    wait_idle();
    chk_copy(4);
    chk_idx("R8 only in-flight slot completes", 5);
    model_slot(5);
    wr(12'h204, 32'h5);
    wait_idle();
    chk_copy(5);

    // wrap 6,7,0,1
    set_slot(6, 32'h600, 32'hA00, 8);
    set_slot(7, 32'h640, 32'hA40, 4);
    set_slot(0, 32'h680, 32'hA80, 16);
    set_slot(1, 32'h6C0, 32'hAC0, 4);
    model_slot(6); model_slot(7); model_slot(0); model_slot(1);
    wr(12'h008, 2);
    wait_idle();
    chk_copy(7); chk_copy(0);
    chk_idx("R6 index wraps through zero", 2);

    // ring reset
    wr(12'h204, 32'h0);
    wr(12'h208, 32'h0001_0001);
    chk_idx("R9 index held at zero", 0);
    wr(12'h008, 0);
    wr(12'h208, 32'h0);
    wr(12'h204, 32'h5);
    repeat (30) @(negedge clk);
    chk_idx("R9 index stays zero after release", 0);
    set_slot(0, 32'h700, 32'hB00, 12);
    model_slot(0);
    wr(12'h008, 1);
    wait_idle();
    chk_copy(0);
    chk_idx("R6 index after reset restart", 1);
    chk("R3 reference queue drained", 32'(q_addr.size()), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    miscompares++;
    $display("FAIL watchdog act=%0d exp=done", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule